// File: doc/BRIEF.md
# Bit Search Unit

The unit accepts a 32-bit word together with a search mode and reports where, counting from the most significant end, the first qualifying bit sits. Three searches are offered. The first looks for a set bit. The second looks for a clear bit. The third looks for the first bit whose value departs from the top bit of the word.

Software writes the word and the mode in a single strobed transfer. Both are captured on that clock edge. The answer then appears on the result outputs from the following cycle. It stays there until the next write.

The index is 0 when the answer is the top bit and 31 when it is the bottom bit. A separate flag and the index value 32 signal that no bit qualified.

Top module: `bsuTop`

## Requirements
- R1: While and after reset, before any write, `resValid` is 0, `resIndex` is 32 and `resNone` is 1.
- R2: A cycle with `wrEn` high captures `wrData` and `wrMode` at that clock edge. The matching result, and `resValid` = 1, are present from the next cycle onward. `resValid` stays 1 until reset.
- R3: Mode 2'b00 (find set bit): `resIndex` = 31 − p, where p is the highest bit position holding 1.
- R4: Mode 2'b01 (find clear bit): `resIndex` = 31 − p, where p is the highest bit position holding 0.
- R5: Mode 2'b10 (find change): the search compares bits 30 down to 0 with bit 31. `resIndex` = 31 − p for the highest such p whose bit differs from bit 31, so any found index lies in 1..31.
- R6: When no bit qualifies in the selected mode, `resIndex` is 32 and `resNone` is 1. Otherwise `resNone` is 0.
- R7: Mode 2'b11 is reserved. It always reports `resIndex` = 32 with `resNone` = 1.
- R8: While `wrEn` is low, changes on `wrData` and `wrMode` leave `resIndex` and `resNone` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for word and mode |
| wrMode | input | 2 | Search mode: 00 set bit, 01 clear bit, 10 change, 11 reserved |
| wrData | input | 32 | Word to be searched |
| resIndex | output | 6 | Position of the first qualifying bit, counted from bit 31; 32 if none |
| resNone | output | 1 | High when no bit qualified |
| resValid | output | 1 | High once a word has been written since reset |

## Verification
Every result is due exactly one clock edge after the write that carries its word and mode. The search itself is combinational behind the capture registers. The bench therefore drives each write on a falling edge and lets one rising edge capture it. It then reads the outputs on the next falling edge, never at a rising edge.

For the hold behaviour, the inputs are disturbed with the strobe low across one further rising edge. The outputs are then read again on the falling edge that follows.

// File: rtl/bsuPkg.sv
package bsuPkg;

  typedef enum logic [1:0] {
    MODE_ONE    = 2'b00,
    MODE_ZERO   = 2'b01,
    MODE_CHANGE = 2'b10,
    MODE_RSVD   = 2'b11
  } scanMode_e;

  // control to datapath strobes
  typedef struct packed {
    logic      loadWord;
    scanMode_e mode;
  } bsuStrobe_t;

endpackage

// File: rtl/bsuLeadScan.sv
module bsuLeadScan #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             none
);

  always_comb begin
    logic hit;
    hit = 1'b0;
    idx = IDX_W'(W);
    for (int i = 0; i < W; i++) begin
      if (!hit && vec[W-1-i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
    none = !hit;
  end

endmodule

// File: rtl/bsuCtrl.sv
module bsuCtrl
  import bsuPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrMode,
  output bsuStrobe_t strobe,
  output logic       resValid
);

  scanMode_e modeQ;
  logic      validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_ONE;
      validQ <= 1'b0;
    end else if (wrEn) begin
      modeQ  <= scanMode_e'(wrMode);
      validQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.loadWord = wrEn;
    strobe.mode     = modeQ;
  end

  assign resValid = validQ;

  AST_WRITE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> resValid); // R2
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> resValid); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(strobe.mode)); // R8

endmodule

// File: rtl/bsuDatapath.sv
module bsuDatapath
  import bsuPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bsuStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [IDX_W-1:0]  resIndex,
  output logic              resNone
);

  logic [DATA_W-1:0] wordQ;
  logic [DATA_W-1:0] target;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wordQ <= '0;
    else if (strobe.loadWord) wordQ <= wrData;
  end

  // map each mode onto a leading-one search
  always_comb begin
    unique case (strobe.mode)
      MODE_ONE:    target = wordQ;
      MODE_ZERO:   target = ~wordQ;
      MODE_CHANGE: target = wordQ ^ {DATA_W{wordQ[DATA_W-1]}};
      default:     target = '0;
    endcase
  end

  bsuLeadScan #(.W(DATA_W), .IDX_W(IDX_W)) i_scan (
    .vec  (target),
    .idx  (resIndex),
    .none (resNone)
  );

  AST_CHANGE_NOT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mode == MODE_CHANGE |-> resIndex != '0); // R5
  AST_RSVD_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mode == MODE_RSVD |-> resNone); // R7
  AST_ZERO_WORD_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == MODE_ONE && wordQ == '0) |-> resNone); // R6
  AST_ONES_WORD_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == MODE_ZERO && wordQ == '1) |-> resNone); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadWord |=> ($stable(resIndex) && $stable(resNone))); // R8

endmodule

// File: rtl/bsuTop.sv
module bsuTop
  import bsuPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrMode,
  input  logic [DATA_W-1:0] wrData,
  output logic [IDX_W-1:0]  resIndex,
  output logic              resNone,
  output logic              resValid
);

  bsuStrobe_t strobe;

  bsuCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrMode   (wrMode),
    .strobe   (strobe),
    .resValid (resValid)
  );

  bsuDatapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .resIndex (resIndex),
    .resNone  (resNone)
  );

endmodule

// File: tb/test_bsuTop.sv
module test_bsuTop;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrMode = 2'b00;
  logic [31:0] wrData = '0;
  logic [5:0]  resIndex;
  logic        resNone;
  logic        resValid;

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  bsuTop i_bsuTop (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMode(wrMode), .wrData(wrData),
    .resIndex(resIndex), .resNone(resNone), .resValid(resValid)
  );

  function automatic int expIdx(input logic [1:0] m, input logic [31:0] d);
    for (int i = 0; i < 32; i++) begin
      if (m == 2'b00 && d[31-i] == 1'b1) return i;
      if (m == 2'b01 && d[31-i] == 1'b0) return i;
      if (m == 2'b10 && i > 0 && d[31-i] != d[31]) return i;
    end
    return 32;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] m, input logic [31:0] d);
    int e;
    string req;
    @(negedge clk);
    wrEn = 1'b1; wrMode = m; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    e = expIdx(m, d);
    case (m)
      2'b00: req = "R3";
      2'b01: req = "R4";
      2'b10: req = "R5";
      default: req = "R7";
    endcase
    check({req, " index"}, int'(resIndex), e);
    check({(e == 32) ? "R6" : req, " none"}, int'(resNone), (e == 32) ? 1 : 0);
    check("R2 valid", int'(resValid), 1);
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [5:0]  keepIdx;
    logic        keepNone;
    repeat (3) @(negedge clk);
    check("R1 valid", int'(resValid), 0);
    check("R1 index", int'(resIndex), 32);
    check("R1 none", int'(resNone), 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after release", int'(resValid), 0);
    check("R1 index after release", int'(resIndex), 32);

    for (int m = 0; m < 4; m++) begin
      doWrite(2'(m), 32'h0000_0000);
      doWrite(2'(m), 32'hFFFF_FFFF);
      for (int b = 0; b < 32; b++) begin
        doWrite(2'(m), 32'h1 << b);
        doWrite(2'(m), ~(32'h1 << b));
        doWrite(2'(m), 32'hFFFF_FFFF >> b);
        doWrite(2'(m), 32'hFFFF_FFFF << b);
      end
      lfsr = 32'hACE1_2468 + 32'(m);
      for (int k = 0; k < 100; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        doWrite(2'(m), lfsr);
      end
    end

    // R8: disturb inputs with strobe low
    for (int m = 0; m < 3; m++) begin
      doWrite(2'(m), 32'h00F0_0000);
      keepIdx = resIndex;
      keepNone = resNone;
      wrMode = 2'(m + 1);
      wrData = 32'h8000_0001;
      @(negedge clk);
      check("R8 index hold", int'(resIndex), int'(keepIdx));
      check("R8 none hold", int'(resNone), int'(keepNone));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule